// File: doc/BRIEF.md
# Three-Code Combination Lock Controller

This block is a synchronous combination lock. Three code words are held on input pins. The user presents candidate values one at a time, and each is marked by a single-cycle strobe. Internally the block selects the code for the current step with a small multiplexer. It compares the candidate against that code for equality. A controller then either moves to the next step or drops into an error state.

After three correct entries in a row the lock opens. A single wrong entry makes the lock refuse all further input until a synchronous reset. Open is also terminal until reset.

A parameter picks how the controller stores its state:
- a compact three-bit binary register whose bits drive the outputs directly, or
- a four-bit one-hot shift register that moves right on each correct entry and loads a constant on reset or error.

Both forms give the same outputs on every cycle.

Top module: `combo_lock`

## Requirements
- R1: A synchronous reset puts the lock in step one from any state: select = 01, open low, error low on the following cycle.
- R2: In step one, two or three, a cycle without the entry strobe leaves the state unchanged.
- R3: A strobed entry equal to the selected code advances step one to step two, step two to step three, and step three to open. Select 01 picks code A, 10 picks code B, 11 picks code C.
- R4: A strobed entry that differs from the selected code, in any of the three steps, moves the lock to the error state.
- R5: The error state ignores every entry, correct or not, until reset.
- R6: The open state ignores every entry until reset.
- R7: Open is high only in the open state and error is high only in the error state. Select reads 11 while open and 00 while in error.
- R8: The binary form (ONE_HOT = 0) and the shift-register form (ONE_HOT = 1) produce identical open, error and select outputs on every cycle for the same stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| entry_valid | input | 1 | One-cycle strobe marking a new entered value |
| entry_value | input | WIDTH | Value entered by the user |
| code_a | input | WIDTH | First code word |
| code_b | input | WIDTH | Second code word |
| code_c | input | WIDTH | Third code word |
| is_open | output | 1 | High while the lock is open |
| code_sel | output | 2 | Multiplexer select of the code under test |
| err | output | 1 | High while in the error state |

## Verification
The assertions check these behaviours on every cycle:
- open and error are never high together;
- select is never zero outside the error state;
- both terminal states are sticky;
- a mismatching strobe always leads to error;
- an idle cycle holds the step;
- reset lands in step one.

The bench scenarios show the rest. These are the full three-entry opening sequence, a wrong entry at each of the three positions, and equal code words. The bench also runs the two encodings side by side, which shows that they agree cycle by cycle.

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int WIDTH   = 4,
  parameter bit ONE_HOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             entry_valid,
  input  logic [WIDTH-1:0] entry_value,
  input  logic [WIDTH-1:0] code_a,
  input  logic [WIDTH-1:0] code_b,
  input  logic [WIDTH-1:0] code_c,
  output logic             is_open,
  output logic [1:0]       code_sel,
  output logic             err
);
  logic [WIDTH-1:0] picked;
  logic             match;

  assign picked = (code_sel == 2'b10) ? code_b :
                  (code_sel == 2'b11) ? code_c : code_a;
  assign match  = (entry_value == picked);

  generate
    if (ONE_HOT) begin : g_shift
      logic [3:0] sr;
      logic       armed, ld;
      assign armed = entry_valid & ~sr[0];
      assign ld    = rst | (armed & ~match);
      always_ff @(posedge clk) begin
        if (ld)         sr <= rst ? 4'b1000 : 4'b0000;
        else if (armed) sr <= {1'b0, sr[3:1]};
      end
      assign is_open  = sr[0];
      assign err      = ~|sr;
      assign code_sel = {sr[2] | sr[1] | sr[0], sr[3] | sr[1] | sr[0]};
    end else begin : g_bin
      localparam logic [2:0] B_S1 = 3'b001, B_S2 = 3'b010, B_S3 = 3'b011,
                             B_OPEN = 3'b111, B_ERR = 3'b000;
      logic [2:0] st, nxt;
      always_comb begin
        case (st)
          B_S1:    nxt = B_S2;
          B_S2:    nxt = B_S3;
          default: nxt = B_OPEN;
        endcase
      end
      always_ff @(posedge clk) begin
        if (rst) st <= B_S1;
        else if (st != B_ERR && st != B_OPEN && entry_valid)
          st <= match ? nxt : B_ERR;
      end
      assign is_open  = st[2];
      assign err      = (st == B_ERR);
      assign code_sel = st[1:0];
    end
  endgenerate
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             entry_valid,
  input logic [WIDTH-1:0] entry_value,
  input logic [WIDTH-1:0] code_a,
  input logic [WIDTH-1:0] code_b,
  input logic [WIDTH-1:0] code_c,
  input logic             is_open,
  input logic [1:0]       code_sel,
  input logic             err
);
  logic [WIDTH-1:0] want;
  assign want = (code_sel == 2'b01) ? code_a :
                (code_sel == 2'b10) ? code_b : code_c;

  AST_RESET_STEP1: assert property (@(posedge clk)
    rst |=> (code_sel == 2'b01 && !is_open && !err)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!err && !is_open && !entry_valid) |=> ($stable(code_sel) && !err && !is_open)); // R2
  AST_MISMATCH_ERR: assert property (@(posedge clk) disable iff (rst)
    (!err && !is_open && entry_valid && entry_value != want) |=> err); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R5
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    is_open |=> is_open); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(err && is_open)); // R7
  AST_SEL_LIVE: assert property (@(posedge clk) disable iff (rst)
    !err |-> code_sel != 2'b00); // R7
endmodule

bind combo_lock combo_lock_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_value(entry_value),
  .code_a(code_a), .code_b(code_b), .code_c(code_c),
  .is_open(is_open), .code_sel(code_sel), .err(err)
);

// File: tb/combo_lock_tb.sv
module combo_lock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  // packed {is_open, err, code_sel}
  localparam logic [3:0] E_S1 = 4'b0001, E_S2 = 4'b0010, E_S3 = 4'b0011,
                         E_OPEN = 4'b1011, E_ERR = 4'b0100;

  logic clk = 1'b0, rst = 1'b1, entry_valid = 1'b0;
  logic [W-1:0] entry_value = '0, code_a = 4'h3, code_b = 4'hA, code_c = 4'h6;
  logic o_b, e_b, o_h, e_h;
  logic [1:0] s_b, s_h;
  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  combo_lock #(.WIDTH(W), .ONE_HOT(1'b0)) u_dut (
    .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_value(entry_value),
    .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .is_open(o_b), .code_sel(s_b), .err(e_b));
  combo_lock #(.WIDTH(W), .ONE_HOT(1'b1)) u_dut_shift (
    .clk(clk), .rst(rst), .entry_valid(entry_valid), .entry_value(entry_value),
    .code_a(code_a), .code_b(code_b), .code_c(code_c),
    .is_open(o_h), .code_sel(s_h), .err(e_h));

  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got_b, got_h;
    got_b = {o_b, e_b, s_b};
    got_h = {o_h, e_h, s_h};
    checks++;
    if (got_b !== exp || got_h !== exp) begin
      failures++;
      $display("FAIL %s binary=%b shift=%b expected=%b", req, got_b, got_h, exp);
    end
  endtask

  // R8: lockstep comparison of the two encodings
  always @(negedge clk) if (started && !done) begin
    checks++;
    if ({o_b, e_b, s_b} !== {o_h, e_h, s_h}) begin
      failures++;
      $display("FAIL R8 binary=%b shift=%b expected equal", {o_b, e_b, s_b}, {o_h, e_h, s_h});
    end
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; entry_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic enter(input logic [W-1:0] v);
    @(negedge clk); entry_valid = 1'b1; entry_value = v;
    @(negedge clk); entry_valid = 1'b0; entry_value = ~v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(); started = 1; chk("R1 reset", E_S1);
  endtask

  task automatic t_open_sequence();
    do_reset();
    enter(code_a); chk("R3 step1->2", E_S2);
    idle(3);       chk("R2 hold step2", E_S2);
    enter(code_b); chk("R3 step2->3", E_S3);
    enter(code_c); chk("R3 step3->open", E_OPEN);
  endtask

  task automatic t_open_sticky();
    enter(4'h0);   chk("R6 open ignores wrong", E_OPEN);
    enter(code_a); chk("R6 open ignores code", E_OPEN);
    do_reset();    chk("R1 reset from open", E_S1);
  endtask

  task automatic t_wrong_at(input int pos);
    do_reset();
    if (pos == 1) begin enter(code_b); chk("R4 wrong step1", E_ERR); end
    else if (pos == 2) begin enter(code_a); enter(code_a); chk("R4 wrong step2", E_ERR); end
    else begin enter(code_a); enter(code_b); enter(code_b); chk("R4 wrong step3", E_ERR); end
    chk("R7 err outputs", E_ERR);
  endtask

  task automatic t_err_sticky();
    do_reset(); enter(4'hF); chk("R4 wrong entry", E_ERR);
    enter(code_a); enter(code_b); enter(code_c); chk("R5 err ignores codes", E_ERR);
    do_reset(); chk("R1 reset from err", E_S1);
  endtask

  task automatic t_idle_step1();
    do_reset(); entry_value = 4'hF; idle(4); chk("R2 hold step1", E_S1);
  endtask

  task automatic t_same_codes();
    code_a = 4'h9; code_b = 4'h9; code_c = 4'h9;
    do_reset();
    enter(4'h9); enter(4'h9); chk("R3 equal codes step3", E_S3);
    enter(4'h9); chk("R3 equal codes open", E_OPEN);
    code_a = 4'h3; code_b = 4'hA; code_c = 4'h6;
  endtask

  initial begin
    t_reset_state();
    t_open_sequence();
    t_open_sticky();
    t_wrong_at(1);
    t_wrong_at(2);
    t_wrong_at(3);
    t_err_sticky();
    t_idle_step1();
    t_same_codes();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1; checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule